// File: doc/BRIEF.md
# Single-Wire Slave Bit-Slot Engine

This block is the timing layer of a slave on an open-drain single-wire bus. It watches a line that the bus master and the slave both pull low, and it turns the low pulses it sees into bus events. A long low pulse is a bus reset, and the engine answers it with a presence pulse of its own. A short low pulse is a time slot. In each slot the engine both samples the line as a master write and, if the upper layer asks for a zero, holds the line low as a read reply. The upper layer supplies one transmit bit per slot. For a pure write slot it offers a 1, which leaves the line alone. It collects the received bit and decides which of the two meanings applies. Bytes are assembled least significant bit first by that layer.

Two speeds are supported. The speed flag from the upper layer selects overdrive timing for slot sampling, read-reply hold and presence. A reset of standard length is always reported with a separate flag, so that the upper layer drops back to standard speed. The presence pulse that follows such a reset then uses standard timing. All times are whole multiples of a parameterised number of clock ticks per microsecond. The line input first passes through a synchronizer. An event is measured from the third rising clock edge at which the raw line is seen low, called F below.

Top module: `sw_bitslot_engine`

## Requirements
- R1: While and right after reset, pull_low, reset_seen, reset_std, rx_valid and tx_taken are all 0.
- R2: On every falling edge of the line while the engine is idle, tx_taken is high for exactly one cycle, following edge F.
- R3: If tx_bit is 0 at edge F, pull_low is high for exactly 15 µs of ticks at standard speed (2 µs at overdrive), starting in the same cycle as tx_taken. If tx_bit is 1, pull_low stays 0 for the whole slot.
- R4: rx_valid pulses once per slot, exactly 30 µs of ticks (3 µs at overdrive) after tx_taken. rx_bit is 0 if the line was still low at that sample point and 1 otherwise.
- R5: od_mode, sampled at edge F, selects overdrive timing for that slot's hold, sample and reset limits.
- R6: A low time of at least 480 µs gives a one-cycle reset_seen together with a one-cycle reset_std, whatever od_mode is. The pulse appears on the third clock edge after the line is sampled high again, and the following presence pulse uses standard timing.
- R7: With od_mode set, a low time of at least 48 µs and under 480 µs gives reset_seen with reset_std held at 0, followed by an overdrive presence pulse.
- R8: With od_mode clear, a low time under 480 µs is only a slot. No reset_seen occurs and no presence pulse follows.
- R9: After reset_seen, the engine waits 30 µs (3 µs at overdrive). It then holds pull_low high for 120 µs (12 µs at overdrive) and releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_in | input | 1 | Raw line level (1 = released) |
| od_mode | input | 1 | Overdrive speed selected by the upper layer |
| tx_bit | input | 1 | Bit to answer in the next slot (0 = pull low) |
| pull_low | output | 1 | Enable for the open-drain pulldown |
| reset_seen | output | 1 | One-cycle pulse: a bus reset ended |
| reset_std | output | 1 | One-cycle pulse: that reset had standard length |
| rx_valid | output | 1 | One-cycle strobe: rx_bit is a sampled slot bit |
| rx_bit | output | 1 | Line level at the slot sample point |
| tx_taken | output | 1 | One-cycle strobe: tx_bit was consumed for a slot |

## Verification
A wrong slot counter or a wrong speed choice shows up on the ports one slot later. The rx_valid strobe or the end of pull_low moves off its expected cycle, even if by a single clock. A wrong low-time measurement shows up as a missing or extra reset_seen, or as a presence pulse of the wrong length, on the third edge after the line goes high. A state machine stuck outside the idle state shows up at the next master falling edge, because tx_taken then fails to appear. The bench compares every output against its own schedule of expected events on every clock, so each of these errors is caught in the cycle where it first becomes visible.

// File: rtl/sw_slot_pkg.sv
package sw_slot_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SLOT,
      ST_WAITHI,
      ST_PWAIT,
      ST_PPULSE,
      ST_PREL
   } slot_state_t;

   function automatic int us_to_ticks(input int us, input int tpu);
      return us * tpu;
   endfunction

endpackage

// File: rtl/sw_line_sync.sv
module sw_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic line,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain[STAGES-1];
   end

   assign line = chain[STAGES-1];
   assign fall = prev_q & ~line;
endmodule

// File: rtl/sw_low_timer.sv
module sw_low_timer #(
   parameter int W   = 12,
   parameter int CAP = 1000
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         line,
   output logic [W-1:0] low_cnt
);
   localparam logic [W-1:0] CAP_C = W'(CAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               low_cnt <= '0;
      else if (line)            low_cnt <= '0;
      else if (low_cnt != CAP_C) low_cnt <= low_cnt + 1'b1;
   end

   assert_low_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      low_cnt <= CAP_C);
   assert_low_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(line) |-> low_cnt == '0);
endmodule

// File: rtl/sw_slot_ctrl.sv
module sw_slot_ctrl
   import sw_slot_pkg::*;
#(
   parameter int TICKS_PER_US = 50,
   parameter int LW           = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line,
   input  logic          fall,
   input  logic [LW-1:0] low_cnt,
   input  logic          od_mode,
   input  logic          tx_bit,
   output logic          pull_low,
   output logic          reset_seen,
   output logic          reset_std,
   output logic          rx_valid,
   output logic          rx_bit,
   output logic          tx_taken
);
   localparam int HOLD_S = us_to_ticks(15,  TICKS_PER_US);
   localparam int HOLD_O = us_to_ticks(2,   TICKS_PER_US);
   localparam int SMP_S  = us_to_ticks(30,  TICKS_PER_US);
   localparam int SMP_O  = us_to_ticks(3,   TICKS_PER_US);
   localparam int PW_S   = us_to_ticks(30,  TICKS_PER_US);
   localparam int PW_O   = us_to_ticks(3,   TICKS_PER_US);
   localparam int PL_S   = us_to_ticks(120, TICKS_PER_US);
   localparam int PL_O   = us_to_ticks(12,  TICKS_PER_US);
   localparam int RST_S  = us_to_ticks(480, TICKS_PER_US);
   localparam int RST_O  = us_to_ticks(48,  TICKS_PER_US);
   localparam int CW     = $clog2(PL_S + 1);

   localparam logic [CW-1:0] HOLD_S_M1 = CW'(HOLD_S - 1);
   localparam logic [CW-1:0] HOLD_O_M1 = CW'(HOLD_O - 1);
   localparam logic [CW-1:0] SMP_S_M1  = CW'(SMP_S - 1);
   localparam logic [CW-1:0] SMP_O_M1  = CW'(SMP_O - 1);
   localparam logic [CW-1:0] PW_S_M1   = CW'(PW_S - 1);
   localparam logic [CW-1:0] PW_O_M1   = CW'(PW_O - 1);
   localparam logic [CW-1:0] PL_S_M1   = CW'(PL_S - 1);
   localparam logic [CW-1:0] PL_O_M1   = CW'(PL_O - 1);
   localparam logic [LW-1:0] RST_S_C   = LW'(RST_S);
   localparam logic [LW-1:0] RST_O_C   = LW'(RST_O);

   slot_state_t   state;
   logic [CW-1:0] cnt;
   logic          fast;
   logic [CW-1:0] hold_m1, smp_m1, pw_m1, pl_m1;

   assign hold_m1 = fast ? HOLD_O_M1 : HOLD_S_M1;
   assign smp_m1  = fast ? SMP_O_M1  : SMP_S_M1;
   assign pw_m1   = fast ? PW_O_M1   : PW_S_M1;
   assign pl_m1   = fast ? PL_O_M1   : PL_S_M1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         fast       <= 1'b0;
         pull_low   <= 1'b0;
         reset_seen <= 1'b0;
         reset_std  <= 1'b0;
         rx_valid   <= 1'b0;
         rx_bit     <= 1'b0;
         tx_taken   <= 1'b0;
      end else begin
         reset_seen <= 1'b0;
         reset_std  <= 1'b0;
         rx_valid   <= 1'b0;
         tx_taken   <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (fall) begin
                  state    <= ST_SLOT;
                  cnt      <= '0;
                  fast     <= od_mode;
                  pull_low <= ~tx_bit;
                  tx_taken <= 1'b1;
               end
            end
            ST_SLOT: begin
               if (cnt == hold_m1) pull_low <= 1'b0;
               if (cnt == smp_m1) begin
                  rx_valid <= 1'b1;
                  rx_bit   <= line;
                  state    <= ST_WAITHI;
               end
               cnt <= cnt + 1'b1;
            end
            ST_WAITHI: begin
               if (line) begin
                  cnt <= '0;
                  if (low_cnt >= RST_S_C) begin
                     reset_seen <= 1'b1;
                     reset_std  <= 1'b1;
                     fast       <= 1'b0;
                     state      <= ST_PWAIT;
                  end else if (fast && low_cnt >= RST_O_C) begin
                     reset_seen <= 1'b1;
                     state      <= ST_PWAIT;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_PWAIT: begin
               if (cnt == pw_m1) begin
                  cnt      <= '0;
                  pull_low <= 1'b1;
                  state    <= ST_PPULSE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_PPULSE: begin
               if (cnt == pl_m1) begin
                  pull_low <= 1'b0;
                  state    <= ST_PREL;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_PREL: begin
               if (line) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_tx_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_taken |-> (pull_low == !$past(tx_bit)));
   assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_taken, rx_valid, reset_seen}));
   assert_std_is_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      reset_std |-> reset_seen);
   assert_drive_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pull_low |-> (state == ST_SLOT || state == ST_PPULSE));
   assert_rx_after_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(state) == ST_SLOT);
   assert_reset_from_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
      reset_seen |-> (state == ST_PWAIT && $past(line)));
endmodule

// File: rtl/sw_bitslot_engine.sv
module sw_bitslot_engine #(
   parameter int TICKS_PER_US = 50,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_in,
   input  logic od_mode,
   input  logic tx_bit,
   output logic pull_low,
   output logic reset_seen,
   output logic reset_std,
   output logic rx_valid,
   output logic rx_bit,
   output logic tx_taken
);
   localparam int RST_CAP = sw_slot_pkg::us_to_ticks(480, TICKS_PER_US);
   localparam int LW      = $clog2(RST_CAP + 1);

   initial begin
      if (TICKS_PER_US < 4)  $fatal(1, "TICKS_PER_US must be at least 4");
      if (SYNC_STAGES < 2)   $fatal(1, "SYNC_STAGES must be at least 2");
   end

   logic          line, fall;
   logic [LW-1:0] low_cnt;

   sw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(bus_in), .line(line), .fall(fall)
   );

   sw_low_timer #(.W(LW), .CAP(RST_CAP)) u_timer (
      .clk(clk), .rst_n(rst_n), .line(line), .low_cnt(low_cnt)
   );

   sw_slot_ctrl #(.TICKS_PER_US(TICKS_PER_US), .LW(LW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .line(line), .fall(fall), .low_cnt(low_cnt),
      .od_mode(od_mode), .tx_bit(tx_bit), .pull_low(pull_low),
      .reset_seen(reset_seen), .reset_std(reset_std), .rx_valid(rx_valid),
      .rx_bit(rx_bit), .tx_taken(tx_taken)
   );
endmodule

// File: tb/sw_bitslot_engine_bench.sv
module sw_bitslot_engine_bench;
   localparam int TPU    = 4;
   localparam int HOLD_S = 15 * TPU, HOLD_O = 2 * TPU;
   localparam int SMP_S  = 30 * TPU, SMP_O  = 3 * TPU;
   localparam int PW_S   = 30 * TPU, PW_O   = 3 * TPU;
   localparam int PL_S   = 120 * TPU, PL_O  = 12 * TPU;
   localparam int RST_S  = 480 * TPU, RST_O = 48 * TPU;

   logic clk = 1'b0, rst_n = 1'b0;
   logic m_low = 1'b0, od_mode = 1'b0, tx_bit = 1'b1;
   logic bus_in;
   logic pull_low, reset_seen, reset_std, rx_valid, rx_bit, tx_taken;

   assign bus_in = ~(m_low | pull_low);

   sw_bitslot_engine #(.TICKS_PER_US(TPU)) u_sw_bitslot_engine (
      .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .od_mode(od_mode),
      .tx_bit(tx_bit), .pull_low(pull_low), .reset_seen(reset_seen),
      .reset_std(reset_std), .rx_valid(rx_valid), .rx_bit(rx_bit),
      .tx_taken(tx_taken)
   );

   always #10 clk = ~clk;

   int cyc = 0;
   int tests = 0, fails = 0;
   bit mon_on = 1'b0, done = 1'b0;

   int tx_q[$], rx_q[$], rxv_q[$], rs_q[$], rstd_q[$], ps_q[$], pe_q[$];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic bit hit(ref int q[$]);
      return (q.size() > 0 && q[0] == cyc);
   endfunction

   // Per-clock comparison of every output with the expected schedule
   always @(negedge clk) begin
      if (mon_on) begin
         bit e_tx, e_rx, e_rs, e_std, e_pull;
         while (pe_q.size() > 0 && pe_q[0] < cyc) begin
            void'(pe_q.pop_front()); void'(ps_q.pop_front());
         end
         e_pull = 1'b0;
         foreach (ps_q[i]) if (ps_q[i] <= cyc && cyc <= pe_q[i]) e_pull = 1'b1;
         e_tx = hit(tx_q); e_rx = hit(rx_q); e_rs = hit(rs_q); e_std = hit(rstd_q);
         tests++;
         if (tx_taken !== e_tx) begin
            fails++; $display("FAIL R2 tx_taken cyc=%0d got %b exp %b", cyc, tx_taken, e_tx);
         end
         if (rx_valid !== e_rx) begin
            fails++; $display("FAIL R4 rx_valid cyc=%0d got %b exp %b", cyc, rx_valid, e_rx);
         end else if (e_rx && rx_bit !== rxv_q[0][0]) begin
            fails++; $display("FAIL R4 rx_bit cyc=%0d got %b exp %b", cyc, rx_bit, rxv_q[0][0]);
         end
         if (reset_seen !== e_rs) begin
            fails++; $display("FAIL R6 or R7 or R8 reset_seen cyc=%0d got %b exp %b", cyc, reset_seen, e_rs);
         end
         if (reset_std !== e_std) begin
            fails++; $display("FAIL R6 reset_std cyc=%0d got %b exp %b", cyc, reset_std, e_std);
         end
         if (pull_low !== e_pull) begin
            fails++; $display("FAIL R3 or R9 pull_low cyc=%0d got %b exp %b", cyc, pull_low, e_pull);
         end
         if (e_tx) void'(tx_q.pop_front());
         if (e_rx) begin void'(rx_q.pop_front()); void'(rxv_q.pop_front()); end
         if (e_rs) void'(rs_q.pop_front());
         if (e_std) void'(rstd_q.pop_front());
      end
   end

   // One master low pulse of n cycles, with expected events computed from the requirements
   task automatic pulse(input int n, input bit tx, input bit od);
      int d, hold, smp, pw, pl, extra;
      bit is_rst, is_std, pod;
      @(negedge clk); tx_bit = tx; od_mode = od;
      @(negedge clk);
      d = cyc + 1;
      hold = od ? HOLD_O : HOLD_S;
      smp  = od ? SMP_O : SMP_S;
      tx_q.push_back(d + 2);
      if (!tx) begin ps_q.push_back(d + 2); pe_q.push_back(d + 1 + hold); end
      rx_q.push_back(d + 2 + smp);
      rxv_q.push_back((n > smp) ? 0 : 1);
      is_std = (n >= RST_S);
      is_rst = is_std || (od && n >= RST_O);
      extra = n + smp + 20;
      if (is_rst) begin
         pod = od && !is_std;
         pw = pod ? PW_O : PW_S;
         pl = pod ? PL_O : PL_S;
         rs_q.push_back(d + n + 2);
         if (is_std) rstd_q.push_back(d + n + 2);
         ps_q.push_back(d + n + 2 + pw);
         pe_q.push_back(d + n + 1 + pw + pl);
         extra = n + pw + pl + 20;
      end
      m_low = 1'b1;
      repeat (n) @(negedge clk);
      m_low = 1'b0;
      repeat (extra - n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs held low during reset
      tests++;
      if ({pull_low, reset_seen, reset_std, rx_valid, tx_taken} !== 5'b0) begin
         fails++; $display("FAIL R1 reset state got %b exp 00000",
                           {pull_low, reset_seen, reset_std, rx_valid, tx_taken});
      end
      rst_n = 1'b1;
      mon_on = 1'b1;
      repeat (5) @(negedge clk);
      pulse(32,   1'b1, 1'b0);  // R2 R4: standard write-1
      pulse(320,  1'b1, 1'b0);  // R4: standard write-0
      pulse(20,   1'b0, 1'b0);  // R3: standard read reply 0
      pulse(320,  1'b0, 1'b0);  // R3 R4: reply 0 inside long slot
      pulse(4,    1'b1, 1'b1);  // R5: overdrive write-1
      pulse(40,   1'b1, 1'b1);  // R5: overdrive write-0
      pulse(4,    1'b0, 1'b1);  // R3 R5: overdrive reply 0
      pulse(1200, 1'b1, 1'b0);  // R8: long low without overdrive is no reset
      pulse(2000, 1'b1, 1'b0);  // R6 R9: standard reset and presence
      pulse(240,  1'b1, 1'b1);  // R7 R9: overdrive reset, short presence
      pulse(2000, 1'b1, 1'b1);  // R6: standard-length reset while in overdrive
      pulse(32,   1'b0, 1'b0);  // R2 R3: slot after reset sequences
      repeat (10) @(negedge clk);
      // R2: all scheduled events consumed
      tests++;
      if (tx_q.size() + rx_q.size() + rs_q.size() + rstd_q.size() != 0) begin
         fails++; $display("FAIL R2 pending events got %0d exp 0",
                           tx_q.size() + rx_q.size() + rs_q.size() + rstd_q.size());
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog expired got timeout exp completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule